// File: doc/BRIEF.md
# Display-Busy and Caption-Ready Interrupt Generator

This block turns video timing into two interrupt requests for a display microcontroller. The first source, display-busy, tells software when it may rewrite display memory without visible disturbance. A single mode bit sets how often it fires. In per-line mode it fires each time horizontal blanking begins on an active display line. In per-field mode it fires once when vertical blanking begins.

The second source, caption-ready, fires only while caption acquisition is switched on. It fires when the slice line named in a programmable line register ends. The end of a line is taken as the start of horizontal blanking on that line.

The blanking flags arrive from another timing domain, so they pass through a synchronizer. The line number and the active-line indicator are delayed by the same number of stages, so all four stay aligned. Each source has a one-cycle pulse output and a sticky pending flag that software clears by writing one. Each source also has a request output, which is the pending flag gated by that source's enable. Priority arbitration between the requests happens outside this block.

Top module: `disp_caption_irq`

## Requirements
- R1: After reset both pending flags, both pulses and both requests are 0.
- R2: With `busyVertMode`=0, a rising edge of `hBlank` while `lineActive`=1 gives one busy pulse and sets `busyFlag`.
- R3: With `busyVertMode`=0, a rising edge of `hBlank` while `lineActive`=0 does not set `busyFlag` and gives no busy pulse.
- R4: The mode select decides which blanking flag drives the busy source. With `busyVertMode`=1, a rising edge of `vBlank` raises busy and `hBlank` edges are ignored. With `busyVertMode`=0, `vBlank` edges are ignored.
- R5: With `ccEnable`=1, a rising edge of `hBlank` while `lineNum` equals `ccLine` gives one caption pulse and sets `ccFlag`. This does not depend on `lineActive` or on the busy mode.
- R6: No caption event occurs when `ccEnable`=0 or when `lineNum` differs from `ccLine`. A `vBlank` edge never causes a caption event.
- R7: A pending flag stays set until a cycle in which its clear input (`busyClr` or `ccClr`) is 1. The flag is 0 after that clock edge.
- R8: If a set event and a clear fall on the same clock edge, the flag is set after that edge.
- R9: `busyReq` equals `busyFlag` AND `busyIrqEn`. `ccReq` equals `ccFlag` AND `ccIrqEn`.
- R10: Holding a blanking flag high gives no further event, and a falling edge gives none.
- R11: A pulse is high in the cycle that follows clock edge SYNC_STAGES+1, counted from the first edge at which the changed blanking level is sampled. It lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hBlank | input | 1 | Horizontal blanking flag (asynchronous) |
| vBlank | input | 1 | Vertical blanking flag (asynchronous) |
| lineActive | input | 1 | Current line is an active display line |
| lineNum | input | LINE_W | Current line number |
| busyVertMode | input | 1 | 0: busy source fires per line, 1: busy source fires per field |
| ccEnable | input | 1 | Caption acquisition enabled |
| ccLine | input | LINE_W | Slice line that triggers caption-ready |
| busyIrqEn | input | 1 | Enable for the busy request |
| ccIrqEn | input | 1 | Enable for the caption request |
| busyClr | input | 1 | Write-one clear of the busy flag |
| ccClr | input | 1 | Write-one clear of the caption flag |
| busyPulse | output | 1 | One-cycle busy event |
| ccPulse | output | 1 | One-cycle caption event |
| busyFlag | output | 1 | Sticky busy pending flag |
| ccFlag | output | 1 | Sticky caption pending flag |
| busyReq | output | 1 | Busy interrupt request |
| ccReq | output | 1 | Caption interrupt request |

## Verification
The bench builds the block with LINE_W=5 and SYNC_STAGES=3. This makes the synchronizer deeper than its default, so the bench can check that the line number and active indicator stay aligned with the blanking edge across every stage. With 5-bit line numbers, the highest line value, 31, can be reached, and the bench uses it as a caption line. The latency check then expects the pulse at edge 4, so an off-by-one error in the pipeline depth shows up as an early or late pulse.

// File: rtl/disp_caption_irq_pkg.sv
package disp_caption_irq_pkg;

  // Conditions found by the datapath in the synchronised video timing
  typedef struct packed {
    logic hEntry;     // horizontal blanking just began
    logic vEntry;     // vertical blanking just began
    logic lineActive; // aligned active-line indicator
    logic lineMatch;  // aligned line number equals caption line
  } vidEvents_t;

  // Strobes from control to the flag registers in the datapath
  typedef struct packed {
    logic setBusy;
    logic setCc;
    logic clrBusy;
    logic clrCc;
  } irqStrobes_t;

endpackage

// File: rtl/disp_caption_irq_dp.sv
module disp_caption_irq_dp
  import disp_caption_irq_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hBlank,
  input  logic              vBlank,
  input  logic              lineActive,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [LINE_W-1:0] ccLine,
  input  irqStrobes_t       strobes,
  output vidEvents_t        events,
  output logic              busyFlag,
  output logic              ccFlag,
  output logic              busyPulse,
  output logic              ccPulse
);

  localparam int LAST = SYNC_STAGES - 1;

  logic              hPipe   [SYNC_STAGES];
  logic              vPipe   [SYNC_STAGES];
  logic              actPipe [SYNC_STAGES];
  logic [LINE_W-1:0] linePipe[SYNC_STAGES];
  logic              hPrev;
  logic              vPrev;

  // Blanking synchroniser, with the line number and the active flag
  // delayed by the same number of stages so that they stay aligned
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hPipe[g]    <= 1'b0;
          vPipe[g]    <= 1'b0;
          actPipe[g]  <= 1'b0;
          linePipe[g] <= '0;
        end else begin
          hPipe[g]    <= hBlank;
          vPipe[g]    <= vBlank;
          actPipe[g]  <= lineActive;
          linePipe[g] <= lineNum;
        end
      end
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hPipe[g]    <= 1'b0;
          vPipe[g]    <= 1'b0;
          actPipe[g]  <= 1'b0;
          linePipe[g] <= '0;
        end else begin
          hPipe[g]    <= hPipe[g-1];
          vPipe[g]    <= vPipe[g-1];
          actPipe[g]  <= actPipe[g-1];
          linePipe[g] <= linePipe[g-1];
        end
      end
    end
  end

  // Previous synchronised levels, used to find the rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
    end else begin
      hPrev <= hPipe[LAST];
      vPrev <= vPipe[LAST];
    end
  end

  always_comb begin
    events.hEntry     = hPipe[LAST] & ~hPrev;
    events.vEntry     = vPipe[LAST] & ~vPrev;
    events.lineActive = actPipe[LAST];
    events.lineMatch  = (linePipe[LAST] == ccLine);
  end

  // Sticky pending flags (a set beats a clear) and one-cycle pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyFlag  <= 1'b0;
      ccFlag    <= 1'b0;
      busyPulse <= 1'b0;
      ccPulse   <= 1'b0;
    end else begin
      busyFlag  <= strobes.setBusy | (busyFlag & ~strobes.clrBusy);
      ccFlag    <= strobes.setCc   | (ccFlag   & ~strobes.clrCc);
      busyPulse <= strobes.setBusy;
      ccPulse   <= strobes.setCc;
    end
  end

endmodule

// File: rtl/disp_caption_irq_ctl.sv
module disp_caption_irq_ctl
  import disp_caption_irq_pkg::*;
(
  input  vidEvents_t  events,
  input  logic        busyVertMode,
  input  logic        ccEnable,
  input  logic        busyClr,
  input  logic        ccClr,
  output irqStrobes_t strobes
);

  logic lineTrig;
  logic fieldTrig;

  always_comb begin
    // Per-line trigger counts only on active display lines
    lineTrig  = events.hEntry & events.lineActive;
    fieldTrig = events.vEntry;

    strobes.setBusy = busyVertMode ? fieldTrig : lineTrig;
    // Caption line ends when horizontal blanking starts on that line
    strobes.setCc   = ccEnable & events.hEntry & events.lineMatch;
    strobes.clrBusy = busyClr;
    strobes.clrCc   = ccClr;
  end

endmodule

// File: rtl/disp_caption_irq.sv
module disp_caption_irq
  import disp_caption_irq_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hBlank,
  input  logic              vBlank,
  input  logic              lineActive,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              busyVertMode,
  input  logic              ccEnable,
  input  logic [LINE_W-1:0] ccLine,
  input  logic              busyIrqEn,
  input  logic              ccIrqEn,
  input  logic              busyClr,
  input  logic              ccClr,
  output logic              busyPulse,
  output logic              ccPulse,
  output logic              busyFlag,
  output logic              ccFlag,
  output logic              busyReq,
  output logic              ccReq
);

  vidEvents_t  events;
  irqStrobes_t strobes;

  disp_caption_irq_dp #(
    .LINE_W     (LINE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .hBlank    (hBlank),
    .vBlank    (vBlank),
    .lineActive(lineActive),
    .lineNum   (lineNum),
    .ccLine    (ccLine),
    .strobes   (strobes),
    .events    (events),
    .busyFlag  (busyFlag),
    .ccFlag    (ccFlag),
    .busyPulse (busyPulse),
    .ccPulse   (ccPulse)
  );

  disp_caption_irq_ctl uCtl (
    .events      (events),
    .busyVertMode(busyVertMode),
    .ccEnable    (ccEnable),
    .busyClr     (busyClr),
    .ccClr       (ccClr),
    .strobes     (strobes)
  );

  assign busyReq = busyFlag & busyIrqEn;
  assign ccReq   = ccFlag & ccIrqEn;

endmodule

// File: rtl/disp_caption_irq_chk.sv
module disp_caption_irq_chk (
  input logic clk,
  input logic rstN,
  input logic ccEnable,
  input logic busyIrqEn,
  input logic ccIrqEn,
  input logic busyClr,
  input logic ccClr,
  input logic busyPulse,
  input logic ccPulse,
  input logic busyFlag,
  input logic ccFlag,
  input logic busyReq,
  input logic ccReq
);

  assert_busy_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    busyPulse |=> !busyPulse);

  assert_cc_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    ccPulse |=> !ccPulse);

  assert_busy_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && !busyClr) |=> busyFlag);

  assert_cc_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ccFlag && !ccClr) |=> ccFlag);

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> busyPulse);

  assert_busy_setwins_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyPulse |-> busyFlag);

  assert_cc_setwins_R8: assert property (@(posedge clk) disable iff (!rstN)
    ccPulse |-> ccFlag);

  assert_cc_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    ccPulse |-> $past(ccEnable));

  assert_busy_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busyIrqEn |-> !busyReq);

  assert_cc_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ccIrqEn |-> !ccReq);

endmodule

bind disp_caption_irq disp_caption_irq_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ccEnable (ccEnable),
  .busyIrqEn(busyIrqEn),
  .ccIrqEn  (ccIrqEn),
  .busyClr  (busyClr),
  .ccClr    (ccClr),
  .busyPulse(busyPulse),
  .ccPulse  (ccPulse),
  .busyFlag (busyFlag),
  .ccFlag   (ccFlag),
  .busyReq  (busyReq),
  .ccReq    (ccReq)
);

// File: tb/sim_disp_caption_irq.sv
module sim_disp_caption_irq;

  localparam int CLK_PERIOD = 10;
  localparam int LW         = 5;
  localparam int SYNC       = 3;
  localparam int LAT        = SYNC + 1;
  localparam int NVEC       = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hBlank = 1'b0, vBlank = 1'b0, lineActive = 1'b0;
  logic [LW-1:0] lineNum = '0, ccLine = '0;
  logic          busyVertMode = 1'b0, ccEnable = 1'b0;
  logic          busyIrqEn = 1'b1, ccIrqEn = 1'b1;
  logic          busyClr = 1'b0, ccClr = 1'b0;
  logic          busyPulse, ccPulse, busyFlag, ccFlag, busyReq, ccReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_caption_irq #(.LINE_W(LW), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rstN(rstN), .hBlank(hBlank), .vBlank(vBlank),
    .lineActive(lineActive), .lineNum(lineNum), .busyVertMode(busyVertMode),
    .ccEnable(ccEnable), .ccLine(ccLine), .busyIrqEn(busyIrqEn),
    .ccIrqEn(ccIrqEn), .busyClr(busyClr), .ccClr(ccClr),
    .busyPulse(busyPulse), .ccPulse(ccPulse), .busyFlag(busyFlag),
    .ccFlag(ccFlag), .busyReq(busyReq), .ccReq(ccReq)
  );

  typedef struct packed {
    logic          vert;
    logic          ccEn;
    logic          act;
    logic          useV;
    logic [LW-1:0] line;
    logic [LW-1:0] ccl;
    logic          expBusy;
    logic          expCc;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 5'd3,  5'd5,  1'b1, 1'b0}, // R2 active line
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd3,  5'd5,  1'b0, 1'b0}, // R3 inactive line
    '{1'b0, 1'b1, 1'b1, 1'b0, 5'd5,  5'd5,  1'b1, 1'b1}, // R5 both fire
    '{1'b0, 1'b1, 1'b0, 1'b0, 5'd5,  5'd5,  1'b0, 1'b1}, // R5 caption on inactive line
    '{1'b0, 1'b0, 1'b1, 1'b0, 5'd5,  5'd5,  1'b1, 1'b0}, // R6 acquisition off
    '{1'b0, 1'b1, 1'b1, 1'b0, 5'd6,  5'd5,  1'b1, 1'b0}, // R6 line mismatch
    '{1'b0, 1'b1, 1'b1, 1'b1, 5'd5,  5'd5,  1'b0, 1'b0}, // R4 vBlank ignored in line mode
    '{1'b1, 1'b0, 1'b1, 1'b1, 5'd0,  5'd5,  1'b1, 1'b0}, // R4 field mode
    '{1'b1, 1'b0, 1'b1, 1'b0, 5'd3,  5'd5,  1'b0, 1'b0}, // R4 hBlank ignored in field mode
    '{1'b1, 1'b1, 1'b0, 1'b0, 5'd31, 5'd31, 1'b0, 1'b1}, // R5 top line value
    '{1'b1, 1'b1, 1'b1, 1'b1, 5'd31, 5'd31, 1'b1, 1'b0}  // R6 vBlank no caption
  };

  vec_t v;
  int   cnt;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    @(negedge clk);
    busyClr = 1'b1;
    ccClr   = 1'b1;
    @(negedge clk);
    busyClr = 1'b0;
    ccClr   = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busyFlag", busyFlag, 1'b0);
    chk("R1 ccFlag", ccFlag, 1'b0);
    chk("R1 busyPulse", busyPulse, 1'b0);
    chk("R1 ccPulse", ccPulse, 1'b0);
    chk("R1 busyReq", busyReq, 1'b0);
    chk("R1 ccReq", ccReq, 1'b0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      @(negedge clk);
      busyVertMode = v.vert;
      ccEnable     = v.ccEn;
      lineActive   = v.act;
      lineNum      = v.line;
      ccLine       = v.ccl;
      idle(SYNC + 2);
      clearAll();
      if (v.useV) vBlank = 1'b1;
      else        hBlank = 1'b1;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2-vector %0d busyPulse", i), busyPulse, v.expBusy);
      chk($sformatf("R5-vector %0d ccPulse", i), ccPulse, v.expCc);
      @(negedge clk);
      chk($sformatf("R7-vector %0d busyFlag", i), busyFlag, v.expBusy);
      chk($sformatf("R7-vector %0d ccFlag", i), ccFlag, v.expCc);
      hBlank = 1'b0;
      vBlank = 1'b0;
      idle(SYNC + 3);
    end

    // R11 latency, R10 single event while held and none on fall
    busyVertMode = 1'b0;
    ccEnable     = 1'b0;
    lineActive   = 1'b1;
    lineNum      = 5'd2;
    clearAll();
    hBlank = 1'b1;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    chk("R11 pulse not early", busyPulse, 1'b0);
    @(negedge clk);
    chk("R11 pulse at latency", busyPulse, 1'b1);
    @(negedge clk);
    chk("R11 pulse one cycle", busyPulse, 1'b0);
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (busyPulse) cnt++;
    end
    chk("R10 held level no retrigger", cnt != 0, 1'b0);
    hBlank = 1'b0;
    cnt = 0;
    for (int k = 0; k < SYNC + 4; k++) begin
      @(negedge clk);
      if (busyPulse) cnt++;
    end
    chk("R10 falling edge no event", cnt != 0, 1'b0);

    // R7 sticky hold, R9 request gating, R7 clear
    chk("R7 flag held", busyFlag, 1'b1);
    busyIrqEn = 1'b0;
    @(negedge clk);
    chk("R9 req masked", busyReq, 1'b0);
    busyIrqEn = 1'b1;
    @(negedge clk);
    chk("R9 req unmasked", busyReq, 1'b1);
    busyClr = 1'b1;
    @(negedge clk);
    busyClr = 1'b0;
    chk("R7 flag cleared", busyFlag, 1'b0);
    chk("R9 req after clear", busyReq, 1'b0);

    // R8 set and clear on the same edge, both sources
    ccEnable = 1'b1;
    ccLine   = 5'd9;
    lineNum  = 5'd9;
    idle(SYNC + 2);
    clearAll();
    hBlank = 1'b1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    busyClr = 1'b1;
    ccClr   = 1'b1;
    @(negedge clk);
    busyClr = 1'b0;
    ccClr   = 1'b0;
    chk("R8 busy set wins", busyFlag, 1'b1);
    chk("R8 cc set wins", ccFlag, 1'b1);
    chk("R8 busy pulse", busyPulse, 1'b1);
    ccIrqEn = 1'b0;
    @(negedge clk);
    chk("R9 cc req masked", ccReq, 1'b0);
    ccIrqEn = 1'b1;
    @(negedge clk);
    chk("R9 cc req unmasked", ccReq, 1'b1);
    hBlank = 1'b0;
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule